// File: doc/BRIEF.md
# Operating Mode Transition Controller

This block holds the operating mode of a small microcontroller and moves it between three running modes (high-speed active, medium-speed active, subactive) and four halted modes (sleep, subsleep, standby, watch). When the CPU issues a sleep request, the block picks the next mode from a small configuration register. That register holds a direct-transfer flag, a medium-speed flag, a low-speed flag, a standby-enable flag and a watch-timer-enable flag. When the direct-transfer flag is set, certain flag combinations move the CPU straight from one running mode to another, with no halted mode in between. A single wake-up pulse ends any halted mode. The mode it resumes in depends on the halted mode and on the flags.

The same register also holds a two-bit selector for the CPU clock divider used in subactive mode. The block decodes that selector into a divide ratio. Writes to the selector are dropped while the CPU runs in subactive mode, so the clock cannot change under it. The register is written through a plain write strobe with a data word. The block reports the current mode as a one-hot vector and gives a one-cycle pulse whenever the mode changes.

Top module: `pmc_top`

## Requirements
- R1: After reset the mode is high-speed active, the configuration register reads as all zeros (so the divide ratio is 8), and `modeChange` is low.
- R2: `cfgWdata` layout: [1:0] clock select, [2] medium-speed flag, [3] direct-transfer flag, [4] low-speed flag, [5] standby-enable, [6] watch-timer-enable. `modeOneHot` bits: 0 high-speed, 1 medium-speed, 2 subactive, 3 sleep, 4 subsleep, 5 standby, 6 watch. Both update on the clock edge that samples the write or the request.
- R3: With direct-transfer clear, a sleep request in either active mode goes to sleep when standby-enable is 0. It goes to standby when standby-enable is 1 and watch-timer is 0, and to watch when both are 1.
- R4: With direct-transfer clear, a sleep request in subactive mode goes to subsleep when standby-enable is 0 and to watch when it is 1.
- R5: With direct-transfer set, in high-speed mode: standby=0, medium=1, low=0 goes to medium-speed; standby=1, timer=1, low=1 goes to subactive.
- R6: With direct-transfer set, in medium-speed mode: standby=0, medium=0, low=0 goes to high-speed; standby=1, timer=1, low=1 goes to subactive.
- R7: With direct-transfer set, in subactive mode, standby=1, timer=1, low=0 goes to medium-speed if medium=1 and to high-speed otherwise.
- R8: With direct-transfer set and no combination of R5 to R7 matching, a sleep request behaves as in R3 or R4.
- R9: A wake-up pulse in sleep or standby resumes medium-speed if the medium flag is 1 and high-speed otherwise.
- R10: A wake-up pulse in watch resumes subactive if the low-speed flag is 1, and otherwise the active mode chosen by the medium flag. A wake-up pulse in subsleep resumes subactive.
- R11: A sleep request in a halted mode does not change the mode. A wake-up pulse in a running mode does not change the mode.
- R12: The divide ratio output is 8 for select 00, 4 for 01, and 2 for 10 or 11.
- R13: While in subactive mode, writes leave the clock select unchanged, but all other configuration fields still take the written value.
- R14: `modeChange` is high for exactly the one cycle after each edge that changes the mode, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 7 | Configuration write data (layout in R2) |
| sleepReq | input | 1 | Sleep request from the CPU |
| wakeUp | input | 1 | Wake-up pulse |
| modeOneHot | output | 7 | Current mode, one-hot |
| modeChange | output | 1 | One-cycle pulse after a mode change |
| subDivRatio | output | 4 | Subactive CPU clock divide ratio |

## Verification
The assertions check these on every cycle: the change pulse matches an actual change of the one-hot mode, requests that do not apply to the current mode leave the mode alone, wake-up from subsleep and from sleep or standby lands in the right class of mode, and the clock select stays fixed during subactive mode. The exact target of each sleep request for every flag combination, the flag-dependent resume mode, and the divide ratio values only show up in the bench's sweep. That sweep covers all 32 flag settings from each of the three running modes and compares each result with an independent model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int NUM_MODES = 7;
  localparam int CFG_W     = 7;

  typedef enum logic [2:0] {
    M_HIGH     = 3'd0,
    M_MED      = 3'd1,
    M_SUB      = 3'd2,
    M_SLEEP    = 3'd3,
    M_SUBSLEEP = 3'd4,
    M_STBY     = 3'd5,
    M_WATCH    = 3'd6
  } modeIdx_t;

  // configuration word as written on the bus, msb first
  typedef struct packed {
    logic       timerEn;
    logic       stbyEn;
    logic       lowSpdOn;
    logic       directOn;
    logic       midSpdOn;
    logic [1:0] subClkSel;
  } cfgWord_t;

  // flags the mode sequencer needs
  typedef struct packed {
    logic timerEn;
    logic stbyEn;
    logic lowSpdOn;
    logic directOn;
    logic midSpdOn;
  } modeCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic inSubactive;
    logic modeTick;
  } ctrlStrobe_t;

endpackage

// File: rtl/pmc_cfg_regs.sv
module pmc_cfg_regs
  import pmc_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  ctrlStrobe_t       strobe,
  output modeCfg_t          modeCfg,
  output logic [DIV_W-1:0]  subDivRatio
);

  localparam int SHIFT_W = (DIV_W > 1) ? $clog2(DIV_W) : 1;

  cfgWord_t cfgReg;
  cfgWord_t wrWord;

  assign wrWord = cfgWord_t'(cfgWdata);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWe) begin
      cfgReg.timerEn  <= wrWord.timerEn;
      cfgReg.stbyEn   <= wrWord.stbyEn;
      cfgReg.lowSpdOn <= wrWord.lowSpdOn;
      cfgReg.directOn <= wrWord.directOn;
      cfgReg.midSpdOn <= wrWord.midSpdOn;
      if (!strobe.inSubactive) begin
        cfgReg.subClkSel <= wrWord.subClkSel;
      end
    end
  end

  assign modeCfg = '{timerEn:  cfgReg.timerEn,
                     stbyEn:   cfgReg.stbyEn,
                     lowSpdOn: cfgReg.lowSpdOn,
                     directOn: cfgReg.directOn,
                     midSpdOn: cfgReg.midSpdOn};

  // ratio = 2^shift: select 00 -> 3, 01 -> 2, 1x -> 1
  logic [SHIFT_W-1:0] divShift;

  always_comb begin
    if (cfgReg.subClkSel[1])      divShift = SHIFT_W'(1);
    else if (cfgReg.subClkSel[0]) divShift = SHIFT_W'(2);
    else                          divShift = SHIFT_W'(3);
  end

  assign subDivRatio = DIV_W'(1) << divShift;

  // R13: select frozen while running from the subactive clock
  a_r13_sel_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inSubactive |=> $stable(cfgReg.subClkSel));

  // R12: ratio always one of the legal powers of two
  a_r12_ratio_legal: assert property (@(posedge clk) disable iff (!rstN)
    $countones(subDivRatio) == 1 && subDivRatio[0] == 1'b0);

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sleepReq,
  input  logic                  wakeUp,
  input  modeCfg_t              modeCfg,
  output logic [NUM_MODES-1:0]  modeOneHot,
  output logic                  modeChange,
  output ctrlStrobe_t           strobe
);

  modeIdx_t curMode;
  modeIdx_t nextMode;
  modeIdx_t sleepTarget;
  modeIdx_t haltTarget;
  modeIdx_t resumeActive;
  logic     isHalted;

  assign isHalted = (curMode == M_SLEEP) || (curMode == M_SUBSLEEP) ||
                    (curMode == M_STBY)  || (curMode == M_WATCH);

  assign resumeActive = modeCfg.midSpdOn ? M_MED : M_HIGH;

  // halted mode picked when no direct move applies
  always_comb begin
    if (curMode == M_SUB)       haltTarget = modeCfg.stbyEn ? M_WATCH : M_SUBSLEEP;
    else if (!modeCfg.stbyEn)   haltTarget = M_SLEEP;
    else if (modeCfg.timerEn)   haltTarget = M_WATCH;
    else                        haltTarget = M_STBY;
  end

  logic toSubOk;
  logic fromSubOk;
  assign toSubOk   = modeCfg.stbyEn && modeCfg.timerEn && modeCfg.lowSpdOn;
  assign fromSubOk = modeCfg.stbyEn && modeCfg.timerEn && !modeCfg.lowSpdOn;

  always_comb begin
    sleepTarget = haltTarget;
    if (modeCfg.directOn) begin
      unique case (curMode)
        M_HIGH: begin
          if (!modeCfg.stbyEn && modeCfg.midSpdOn && !modeCfg.lowSpdOn) sleepTarget = M_MED;
          else if (toSubOk)                                             sleepTarget = M_SUB;
        end
        M_MED: begin
          if (!modeCfg.stbyEn && !modeCfg.midSpdOn && !modeCfg.lowSpdOn) sleepTarget = M_HIGH;
          else if (toSubOk)                                              sleepTarget = M_SUB;
        end
        M_SUB: begin
          if (fromSubOk) sleepTarget = resumeActive;
        end
        default: sleepTarget = haltTarget;
      endcase
    end
  end

  always_comb begin
    nextMode = curMode;
    if (isHalted) begin
      if (wakeUp) begin
        unique case (curMode)
          M_SUBSLEEP: nextMode = M_SUB;
          M_WATCH:    nextMode = modeCfg.lowSpdOn ? M_SUB : resumeActive;
          default:    nextMode = resumeActive;
        endcase
      end
    end else if (sleepReq) begin
      nextMode = sleepTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curMode    <= M_HIGH;
      modeChange <= 1'b0;
    end else begin
      curMode    <= nextMode;
      modeChange <= (nextMode != curMode);
    end
  end

  assign modeOneHot         = NUM_MODES'(1) << curMode;
  assign strobe.inSubactive = (curMode == M_SUB);
  assign strobe.modeTick    = modeChange;

  // R14: pulse agrees with the observed mode vector
  a_r14_pulse_matches: assert property (@(posedge clk) disable iff (!rstN)
    modeChange == (modeOneHot != $past(modeOneHot)));

  // R11: halted mode holds without wake-up
  a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    (isHalted && !wakeUp) |=> $stable(curMode));

  // R11: running mode holds without sleep request
  a_r11_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!isHalted && !sleepReq) |=> $stable(curMode));

  // R10: subsleep always wakes into subactive
  a_r10_subsleep_wake: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == M_SUBSLEEP && wakeUp) |=> (curMode == M_SUB));

  // R9: sleep and standby resume in an active mode
  a_r9_resume_active: assert property (@(posedge clk) disable iff (!rstN)
    ((curMode == M_SLEEP || curMode == M_STBY) && wakeUp) |=>
      (curMode == M_HIGH || curMode == M_MED));

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [CFG_W-1:0]      cfgWdata,
  input  logic                  sleepReq,
  input  logic                  wakeUp,
  output logic [NUM_MODES-1:0]  modeOneHot,
  output logic                  modeChange,
  output logic [DIV_W-1:0]      subDivRatio
);

  ctrlStrobe_t strobe;
  modeCfg_t    modeCfg;

  pmc_mode_fsm uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .wakeUp     (wakeUp),
    .modeCfg    (modeCfg),
    .modeOneHot (modeOneHot),
    .modeChange (modeChange),
    .strobe     (strobe)
  );

  pmc_cfg_regs #(.DIV_W(DIV_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgWdata    (cfgWdata),
    .strobe      (strobe),
    .modeCfg     (modeCfg),
    .subDivRatio (subDivRatio)
  );

endmodule

// File: tb/tb_pmc_top.sv
`timescale 1ns/1ps
module tb_pmc_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [6:0] cfgWdata = '0;
  logic       sleepReq = 1'b0;
  logic       wakeUp = 1'b0;
  logic [6:0] modeOneHot;
  logic       modeChange;
  logic [3:0] subDivRatio;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pmc_top dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .sleepReq(sleepReq), .wakeUp(wakeUp),
    .modeOneHot(modeOneHot), .modeChange(modeChange), .subDivRatio(subDivRatio)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic writeCfg(input logic [6:0] w);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = w;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic pulseSleep();
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeUp = 1'b1;
    @(negedge clk); wakeUp = 1'b0;
  endtask

  // bit layout: [6] timer [5] standby [4] low [3] direct [2] medium [1:0] clock select
  function automatic int expSleep(input int m, input logic [6:0] c);
    bit t = c[6], s = c[5], l = c[4], d = c[3], md = c[2];
    if (d) begin
      if (m == 0 && !s && md && !l) return 1;
      if (m == 1 && !s && !md && !l) return 0;
      if (m < 2 && s && t && l) return 2;
      if (m == 2 && s && t && !l) return md ? 1 : 0;
    end
    if (m == 2) return s ? 6 : 4;
    if (!s) return 3;
    return t ? 6 : 5;
  endfunction

  function automatic int expWake(input int m, input logic [6:0] c);
    case (m)
      3, 5: return c[2] ? 1 : 0;
      6:    return c[4] ? 2 : (c[2] ? 1 : 0);
      4:    return 2;
      default: return m;
    endcase
  endfunction

  function automatic bit directHit(input int m, input logic [6:0] c);
    return c[3] && (expSleep(m, c) <= 2);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    chk(modeOneHot == 7'b0000001, "R1 mode", modeOneHot, 1);
    chk(subDivRatio == 4'd8, "R1 ratio", subDivRatio, 8);
    chk(modeChange == 1'b0, "R1 pulse", modeChange, 0);

    // R12: divide ratio in high-speed mode, all selects
    for (int sel = 0; sel < 4; sel++) begin
      writeCfg(7'(sel));
      chk(subDivRatio == ((sel >= 2) ? 4'd2 : (sel == 1 ? 4'd4 : 4'd8)),
          "R12 ratio", subDivRatio, (sel >= 2) ? 2 : (sel == 1 ? 4 : 8));
    end

    // R13: select frozen in subactive, other fields still written
    doReset();
    writeCfg(7'b1111001);
    pulseSleep();
    chk(modeOneHot == 7'b0000100, "R13 enter sub", modeOneHot, 4);
    chk(subDivRatio == 4'd4, "R13 ratio before", subDivRatio, 4);
    writeCfg(7'b1111011);
    chk(subDivRatio == 4'd4, "R13 ratio held", subDivRatio, 4);
    writeCfg(7'b1101010);
    chk(subDivRatio == 4'd4, "R13 ratio held2", subDivRatio, 4);
    pulseSleep();
    chk(modeOneHot == 7'b0000001, "R13 other fields written", modeOneHot, 1);
    writeCfg(7'b0000010);
    chk(subDivRatio == 4'd2, "R13 writable again", subDivRatio, 2);

    // R11: ignored requests
    doReset();
    pulseWake();
    chk(modeOneHot == 7'b0000001, "R11 wake in run", modeOneHot, 1);
    chk(modeChange == 1'b0, "R11 no pulse run", modeChange, 0);
    pulseSleep();
    chk(modeOneHot == 7'b0001000, "R3 to sleep", modeOneHot, 8);
    chk(modeChange == 1'b1, "R14 pulse high", modeChange, 1);
    @(negedge clk);
    chk(modeChange == 1'b0, "R14 pulse one cycle", modeChange, 0);
    pulseSleep();
    chk(modeOneHot == 7'b0001000, "R11 sleep in halt", modeOneHot, 8);
    chk(modeChange == 1'b0, "R11 no pulse halt", modeChange, 0);

    // R8: direct set with no matching combination
    doReset();
    writeCfg(7'b0001000);
    pulseSleep();
    chk(modeOneHot == 7'b0001000, "R8 high fallback", modeOneHot, 8);
    doReset();
    writeCfg(7'b1111000);
    pulseSleep();
    writeCfg(7'b0101000);
    pulseSleep();
    chk(modeOneHot == 7'b1000000, "R8 sub fallback", modeOneHot, 64);

    // full sweep of flags from each running mode
    for (int start = 0; start < 3; start++) begin
      for (int f = 0; f < 32; f++) begin
        logic [6:0] c;
        int e;
        int w;
        string tag;
        c = {f[4:0], 2'b00};
        doReset();
        if (start == 1) begin
          writeCfg(7'b0001100);
          pulseSleep();
        end else if (start == 2) begin
          writeCfg(7'b1111000);
          pulseSleep();
        end
        chk(modeOneHot == 7'(1 << start), "R2 start", modeOneHot, 1 << start);
        writeCfg(c);
        pulseSleep();
        e = expSleep(start, c);
        if (directHit(start, c)) tag = (start == 0) ? "R5" : (start == 1 ? "R6" : "R7");
        else if (c[3])           tag = "R8";
        else                     tag = (start == 2) ? "R4" : "R3";
        chk(modeOneHot == 7'(1 << e), tag, modeOneHot, 1 << e);
        chk(modeChange == (e != start), "R14 sweep pulse", modeChange, (e != start));
        if (e >= 3) begin
          pulseWake();
          w = expWake(e, c);
          chk(modeOneHot == 7'(1 << w), (e == 3 || e == 5) ? "R9" : "R10",
              modeOneHot, 1 << w);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule